// File: doc/BRIEF.md
# Descriptor Launch Register

This block is the register front end of a configuration-data transfer engine. Software places a transfer descriptor in memory, then writes the 64-bit memory address of that descriptor into this register. The block assembles the address from one 64-bit bus write, or from two 32-bit writes that arrive upper half first. It then hands the address to the engine with a one-cycle start strobe. Offset 0 holds the upper 32 bits and offset 4 holds the lower 32 bits. Only the write that completes the address starts the engine. A lone lower-half write is enough for a descriptor below 4 GiB.

Reads never return the held address. Every read returns a window of a fixed 64-bit identification constant, 0x51454D5520434647, which software uses to detect the engine. Byte 0 of the constant is its most significant byte. A read at byte offset A with size N returns the N bytes starting at A, zero-extended. While the engine reports busy, a launching write is held off by lowering bus ready. Every other access goes through.

The bus is a simple register port. A request is made of valid, write, a 3-bit byte offset, a size in bytes and 64 bits of write data. The request is taken on a clock edge where both valid and ready are high. Read data appears one cycle later and is marked by a read-valid flag. The 32-bit half of a write is carried on write-data bits 31:0.

Top module: `desc_ptr_port`

## Requirements
- R1: After synchronous reset, start strobe, read valid and the held upper half are all zero, and bus ready is high while no request is pending. The first lower-half write after reset therefore launches {32'h0, value}.
- R2: An accepted 32-bit write (size 4) at offset 0 loads write-data bits 31:0 as the upper half of the address and clears the lower half. It does not produce a start strobe.
- R3: An accepted 32-bit write at offset 4 ORs write-data bits 31:0 into the lower half. One cycle after acceptance it raises the start strobe with start address {upper half, lower half}.
- R4: An accepted 64-bit write (size 8) at offset 0 raises the start strobe one cycle later, with start address equal to the full 64-bit write data.
- R5: Any other write (a size other than 4 or 8, size 4 at an offset other than 0 or 4, or size 8 at a nonzero offset) has no effect. It produces no strobe and leaves the held upper half unchanged.
- R6: Launching an operation clears the held address to zero. A later lower-half write launches {32'h0, value}.
- R7: The start strobe is high for exactly one cycle per launching write and never without one.
- R8: A launching write (R3 or R4) presented while the engine busy input is high sees bus ready low and is not accepted until busy falls. Reads and non-launching writes are never held off.
- R9: An accepted read of N bytes (N = 1, 2, 4 or 8) at offset A, with A+N no greater than 8, gives read valid high for one cycle, one cycle later. Read data equals (0x51454D5520434647 >> ((8-A-N)*8)) masked to N*8 bits.
- R10: A read with A+N greater than 8, or with a size that is not 1, 2, 4 or 8, returns zero read data with read valid.
- R11: Reads do not alter the held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 3 | Byte offset within the register |
| bus_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| bus_wdata | input | 64 | Write data; 32-bit halves on bits 31:0 |
| bus_ready | output | 1 | Request can be taken this cycle |
| rd_valid | output | 1 | Read data valid (one cycle after acceptance) |
| rd_data | output | 64 | Read data, zero-extended |
| eng_busy | input | 1 | Transfer engine is still working |
| start_pulse | output | 1 | One-cycle launch strobe |
| start_addr | output | 64 | Descriptor address carried with the strobe |

## Verification
The bench builds the block with its default parameters: a 64-bit register, a 3-bit offset and a 4-bit size field. These defaults reach every legal offset and every size from 1 to 8. They also reach the byte windows that run past the end of the constant, the unaligned reads, and the whole set of illegal write shapes. Holding the busy input high while a launch is pending exercises the hold-off path. Reads and upper-half writes are also issued under busy to show they are not blocked.

// File: rtl/dtp_pkg.sv
package dtp_pkg;

  typedef enum logic [1:0] {
    WK_NONE,
    WK_HIGH,
    WK_LOW_GO,
    WK_FULL_GO
  } wr_kind_e;

  localparam logic [63:0] DTP_SIGNATURE = 64'h5145_4D55_2043_4647;

endpackage

// File: rtl/dtp_decode.sv
module dtp_decode
  import dtp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 4
) (
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output wr_kind_e          kind
);

  localparam int BYTES      = ADDR_W / 8;
  localparam int HALF_BYTES = BYTES / 2;
  localparam logic [SIZE_W-1:0] SZ_HALF = SIZE_W'(HALF_BYTES);
  localparam logic [SIZE_W-1:0] SZ_FULL = SIZE_W'(BYTES);
  localparam logic [OFF_W-1:0]  OFF_LO  = OFF_W'(HALF_BYTES);

  always_comb begin
    kind = WK_NONE;
    if (wr) begin
      if (size == SZ_HALF && off == '0)
        kind = WK_HIGH;
      else if (size == SZ_HALF && off == OFF_LO)
        kind = WK_LOW_GO;
      else if (size == SZ_FULL && off == '0)
        kind = WK_FULL_GO;
    end
  end

endmodule

// File: rtl/dtp_addr_hold.sv
module dtp_addr_hold
  import dtp_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  wr_kind_e          kind,
  input  logic [ADDR_W-1:0] wdata,
  output logic              start_q,
  output logic [ADDR_W-1:0] start_addr_q
);

  localparam int HALF_W = ADDR_W / 2;

  // Only the upper half is stored: the lower half is zero whenever a
  // lower-half write can arrive, so OR-ing into it is a plain load.
  logic [HALF_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q         <= '0;
      start_q      <= 1'b0;
      start_addr_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        case (kind)
          WK_HIGH: hi_q <= wdata[HALF_W-1:0];
          WK_LOW_GO: begin
            start_q      <= 1'b1;
            start_addr_q <= {hi_q, wdata[HALF_W-1:0]};
            hi_q         <= '0;
          end
          WK_FULL_GO: begin
            start_q      <= 1'b1;
            start_addr_q <= wdata;
            hi_q         <= '0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dtp_sig_read.sv
module dtp_sig_read #(
  parameter int               ADDR_W = 64,
  parameter int               OFF_W  = 3,
  parameter int               SIZE_W = 4,
  parameter logic [ADDR_W-1:0] SIG   = dtp_pkg::DTP_SIGNATURE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_go,
  input  logic [OFF_W-1:0]  off,
  input  logic [SIZE_W-1:0] size,
  output logic              rd_valid_q,
  output logic [ADDR_W-1:0] rd_data_q
);

  localparam int BYTES = ADDR_W / 8;
  localparam int LANES = $clog2(BYTES) + 1;

  logic [ADDR_W-1:0] lane [LANES];
  logic [ADDR_W-1:0] pick;

  // One candidate window per legal power-of-two size.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int NB = 1 << k;
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} >> (ADDR_W - NB * 8);
    assign lane[k] = (int'(off) + NB <= BYTES)
                   ? ((SIG >> ((BYTES - int'(off) - NB) * 8)) & MASK)
                   : '0;
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < LANES; k++) begin
      if (int'(size) == (1 << k)) pick = lane[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_go;
      if (rd_go) rd_data_q <= pick;
    end
  end

endmodule

// File: rtl/desc_ptr_port.sv
module desc_ptr_port
  import dtp_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [OFF_W-1:0]  bus_offset,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic [ADDR_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              eng_busy,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr
);

  wr_kind_e kind;
  logic     launches;
  logic     accept;

  dtp_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_dec (
    .wr   (bus_write),
    .off  (bus_offset),
    .size (bus_size),
    .kind (kind)
  );

  assign launches  = (kind == WK_LOW_GO) || (kind == WK_FULL_GO);
  assign bus_ready = !(bus_valid && launches && eng_busy);
  assign accept    = bus_valid && bus_ready;

  dtp_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .accept       (accept && bus_write),
    .kind         (kind),
    .wdata        (bus_wdata),
    .start_q      (start_pulse),
    .start_addr_q (start_addr)
  );

  dtp_sig_read #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SIZE_W (SIZE_W),
    .SIG    (ADDR_W'(DTP_SIGNATURE))
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_go      (accept && !bus_write),
    .off        (bus_offset),
    .size       (bus_size),
    .rd_valid_q (rd_valid),
    .rd_data_q  (rd_data)
  );

endmodule

// File: rtl/dtp_checker.sv
module dtp_checker #(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 3,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [OFF_W-1:0]  bus_offset,
  input logic [SIZE_W-1:0] bus_size,
  input logic [ADDR_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_data,
  input logic              eng_busy,
  input logic              start_pulse,
  input logic [ADDR_W-1:0] start_addr
);

  localparam int BYTES = ADDR_W / 8;
  localparam int HALFB = BYTES / 2;

  logic lo_go, full_go, launch_req, other_wr;
  assign lo_go      = bus_write && int'(bus_size) == HALFB && int'(bus_offset) == HALFB;
  assign full_go    = bus_write && int'(bus_size) == BYTES && bus_offset == '0;
  assign launch_req = lo_go || full_go;
  assign other_wr   = bus_write && !launch_req &&
                      !(int'(bus_size) == HALFB && bus_offset == '0);

  // R7: a strobe only follows an accepted launching write
  a_r7_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> $past(bus_valid && bus_ready && launch_req));

  // R4: full-width write carries its data to the strobe
  a_r4_full_addr: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ready && full_go) |=> (start_pulse && start_addr == $past(bus_wdata)));

  // R8: launch under busy is held off
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && launch_req && eng_busy) |-> !bus_ready);

  // R8: only a launching write under busy ever sees ready low
  a_r8_ready_only_busy: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |-> (bus_valid && launch_req && eng_busy));

  // R9: read valid follows an accepted read
  a_r9_rd_cause: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_valid && bus_ready && !bus_write));

  // R10: windows past the end read as zero
  a_r10_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && (int'(bus_offset) + int'(bus_size) > BYTES)) |=> (rd_data == '0));

  // R5: illegal write shapes never launch
  a_r5_no_launch: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && other_wr) |=> !start_pulse);

endmodule

bind desc_ptr_port dtp_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .SIZE_W (SIZE_W)
) u_chk (.*);

// File: tb/sim_desc_ptr_port.sv
`timescale 1ns/1ps
module sim_desc_ptr_port;

  localparam logic [63:0] SIG = 64'h5145_4D55_2043_4647;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_offset = '0;
  logic [3:0]  bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_ready;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        eng_busy = 1'b0;
  logic        start_pulse;
  logic [63:0] start_addr;

  always #2 clk = ~clk;

  desc_ptr_port u0 (
    .clk, .rst, .bus_valid, .bus_write, .bus_offset, .bus_size, .bus_wdata,
    .bus_ready, .rd_valid, .rd_data, .eng_busy, .start_pulse, .start_addr
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [63:0] st_q[$];
  string       st_tag[$];
  logic [63:0] rd_q[$];
  string       rd_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input int a, input int n);
    logic [63:0] m;
    if (!(n == 1 || n == 2 || n == 4 || n == 8) || a + n > 8) return '0;
    m = {64{1'b1}} >> (64 - n * 8);
    return (SIG >> ((8 - a - n) * 8)) & m;
  endfunction

  task automatic bus_op(input bit w, input int off, input int sz, input logic [63:0] d);
    @(negedge clk);
    bus_valid  = 1'b1;
    bus_write  = w;
    bus_offset = 3'(off);
    bus_size   = 4'(sz);
    bus_wdata  = d;
    do @(posedge clk); while (!bus_ready);
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic wr_go(input int off, input int sz, input logic [63:0] d, input logic [63:0] exp, input string tag);
    st_q.push_back(exp);
    st_tag.push_back(tag);
    bus_op(1'b1, off, sz, d);
  endtask

  task automatic rd(input int off, input int sz, input string tag);
    rd_q.push_back(exp_read(off, sz));
    rd_tag.push_back(tag);
    bus_op(1'b0, off, sz, '0);
  endtask

  // Monitor / scoreboard
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (start_pulse) begin
        if (prev_pulse) chk(1'b0, "R7 strobe wider than one cycle", 64'd1, 64'd0);
        if (st_q.size() == 0) chk(1'b0, "R7 unexpected strobe", start_addr, 64'd0);
        else begin
          logic [63:0] e;
          string t;
          e = st_q.pop_front();
          t = st_tag.pop_front();
          chk(start_addr == e, t, start_addr, e);
        end
      end
      if (rd_valid) begin
        if (rd_q.size() == 0) chk(1'b0, "R9 unexpected read valid", rd_data, 64'd0);
        else begin
          logic [63:0] e;
          string t;
          e = rd_q.pop_front();
          t = rd_tag.pop_front();
          chk(rd_data == e, t, rd_data, e);
        end
      end
      prev_pulse <= start_pulse;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(start_pulse == 1'b0, "R1 strobe after reset", 64'(start_pulse), 64'd0);
    chk(rd_valid == 1'b0, "R1 read valid after reset", 64'(rd_valid), 64'd0);
    chk(bus_ready == 1'b1, "R1 ready after reset", 64'(bus_ready), 64'd1);
    wr_go(4, 4, 64'hFFFF_FFFF_1234_5678, 64'h0000_0000_1234_5678, "R1 held zero at reset");

    // R2 + R3 split write
    bus_op(1'b1, 0, 4, 64'h0000_0000_DEAD_BEEF);
    wr_go(4, 4, 64'h0000_0000_0BAD_F00D, 64'hDEAD_BEEF_0BAD_F00D, "R3 split launch (R2 upper half)");
    // R6 cleared after launch
    wr_go(4, 4, 64'h11, 64'h0000_0000_0000_0011, "R6 cleared after split launch");

    // R4 full write, then R6
    wr_go(0, 8, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R4 full write launch");
    bus_op(1'b1, 0, 4, 64'h0000_0000_7777_0000);
    wr_go(0, 8, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, "R4 full write overrides upper half");
    wr_go(4, 4, 64'h22, 64'h0000_0000_0000_0022, "R6 cleared after full launch");

    // R5 illegal writes, R11 reads between
    bus_op(1'b1, 0, 4, 64'h0000_0000_CAFE_F00D);
    bus_op(1'b1, 0, 2, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_op(1'b1, 2, 4, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_op(1'b1, 4, 8, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_op(1'b1, 4, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_op(1'b1, 1, 4, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_op(1'b1, 0, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_op(1'b1, 6, 2, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, 8, "R11 read between writes");
    rd(4, 4, "R11 read between writes");
    wr_go(4, 4, 64'h33, 64'hCAFE_F00D_0000_0033, "R5 illegal writes left upper half (R11)");

    // R9 windows
    rd(0, 8, "R9 full signature");
    rd(0, 4, "R9 upper word");
    rd(4, 4, "R9 lower word");
    rd(6, 2, "R9 halfword at 6");
    rd(1, 2, "R9 unaligned halfword");
    rd(3, 1, "R9 byte at 3");
    rd(7, 1, "R9 last byte");
    rd(0, 1, "R9 first byte");
    // R10 zero cases
    rd(6, 4, "R10 word past end");
    rd(1, 8, "R10 dword past end");
    rd(7, 2, "R10 halfword past end");
    rd(0, 3, "R10 unsupported size");
    rd(0, 0, "R10 zero size");

    // R8 busy hold-off
    eng_busy = 1'b1;
    rd(4, 4, "R8 read under busy");
    bus_op(1'b1, 0, 4, 64'h0000_0000_5A5A_5A5A);
    st_q.push_back(64'h5A5A_5A5A_0000_0044);
    st_tag.push_back("R8 launch after busy drops");
    fork
      bus_op(1'b1, 4, 4, 64'h44);
      begin
        repeat (4) @(negedge clk);
        #1;
        chk(bus_ready == 1'b0, "R8 ready low under busy", 64'(bus_ready), 64'd0);
        chk(start_pulse == 1'b0, "R8 no strobe under busy", 64'(start_pulse), 64'd0);
        eng_busy = 1'b0;
      end
    join
    eng_busy = 1'b1;
    st_q.push_back(64'hAAAA_BBBB_CCCC_DDDD);
    st_tag.push_back("R8 full launch after busy drops");
    fork
      bus_op(1'b1, 0, 8, 64'hAAAA_BBBB_CCCC_DDDD);
      begin
        repeat (3) @(negedge clk);
        #1;
        chk(bus_ready == 1'b0, "R8 ready low for full write", 64'(bus_ready), 64'd0);
        eng_busy = 1'b0;
      end
    join

    repeat (4) @(negedge clk);
    chk(st_q.size() == 0, "R7 missing strobes", 64'(st_q.size()), 64'd0);
    chk(rd_q.size() == 0, "R9 missing reads", 64'(rd_q.size()), 64'd0);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule